// File: doc/BRIEF.md
# Pedestal-Corrected Window Hit Filter

This block sits behind a multi-channel converter and decides, one conversion at a time, whether a channel produced a result worth reading out. Each raw conversion arrives with its channel index. The block can add a signed offset held for that channel and clamp the sum into the unsigned data range. It then compares the corrected value against a lower and an upper limit, also held per channel. A channel that passes sets its bit in a sticky hit register. A service request output is raised while any hit bit is set and requests are enabled.

The offsets and limits sit in three small per-channel tables. All three share one write port, and a select register steers each write to one table. A three-bit control register switches the offset stage, the lower test and the upper test on or off separately. Hit bits can be cleared all at once or one channel at a time, which is how a readout drains them. A module clear returns the control state to its idle condition and leaves the tables untouched.

Top module: `hit_window_filter`

## Requirements
- R1: After reset the hit register is all zeros, the request output `lam` is low and `corr_valid` is low.
- R2: A conversion accepted on one rising edge appears on `corr_valid`, `corr_ch` and `corr_data` after that edge. When the offset stage is off (control bit 0 clear), `corr_data` equals the raw value. When it is on, `corr_data` equals the raw value plus that channel's offset.
- R3: The corrected value is clamped: a sum below 0 gives 0, and a sum above 4095 gives 4095. Offsets are 13-bit two's complement values.
- R4: With the lower test on (control bit 1), a channel passes only if its corrected value is at least its lower limit. A value equal to the limit passes.
- R5: With the upper test on (control bit 2), a channel passes only if its corrected value is at most its upper limit. A value equal to the limit passes.
- R6: A test that is switched off always passes. With control at zero, every conversion sets its channel's hit bit.
- R7: Hit bits are sticky. A conversion sets at most the bit of its own channel, and a failing conversion clears no bit.
- R8: The select register routes parameter writes: 0 to the offset table, 1 to the lower limits, 2 to the upper limits. While it holds 3, a parameter write changes no table.
- R9: `lam` is high exactly when requests are enabled and at least one hit bit is set. `lam_en_set` enables requests and `lam_en_clr` disables them.
- R10: `hit_clr` clears every hit bit and `hit_ack_valid` clears the bit selected by `hit_ack_ch`. A conversion that passes in the same cycle still sets its bit.
- R11: `mod_clr` clears the control register, the request enable and all hit bits, and it overrides every other input in its cycle. The parameter tables keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Write the control register |
| ctl_wdata | input | 3 | Control value: bit 0 offset, bit 1 lower test, bit 2 upper test |
| sel_we | input | 1 | Write the parameter select register |
| sel_wdata | input | 2 | Table select: 0 offset, 1 lower, 2 upper, 3 none |
| par_we | input | 1 | Write one parameter entry |
| par_ch | input | 4 | Channel of the parameter entry |
| par_wdata | input | 13 | Parameter value; limits use the low 12 bits |
| conv_valid | input | 1 | A raw conversion is present |
| conv_ch | input | 4 | Channel of the conversion |
| conv_data | input | 12 | Raw unsigned conversion |
| lam_en_set | input | 1 | Enable the request output |
| lam_en_clr | input | 1 | Disable the request output |
| hit_clr | input | 1 | Clear all hit bits |
| hit_ack_valid | input | 1 | Clear one hit bit |
| hit_ack_ch | input | 4 | Channel whose hit bit is cleared |
| mod_clr | input | 1 | Module clear |
| corr_valid | output | 1 | Corrected value valid |
| corr_ch | output | 4 | Channel of the corrected value |
| corr_data | output | 12 | Corrected, clamped value |
| hit | output | 16 | Hit register |
| lam | output | 1 | Service request |

## Verification
The bench uses the default parameters: sixteen channels and 12-bit data with 13-bit offsets. With these values both clamp points, 0 and 4095, can be reached with legal offsets. The limit tests are exercised one count on each side of a limit. Channel indices spread across the register show that hits stay sticky and are cleared per channel.

// File: rtl/hit_window_filter.sv
module hit_window_filter #(
  parameter int NCH = 16,
  parameter int DW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_wdata,
  input  logic              sel_we,
  input  logic [1:0]        sel_wdata,
  input  logic              par_we,
  input  logic [$clog2(NCH)-1:0] par_ch,
  input  logic [DW:0]       par_wdata,
  input  logic              conv_valid,
  input  logic [$clog2(NCH)-1:0] conv_ch,
  input  logic [DW-1:0]     conv_data,
  input  logic              lam_en_set,
  input  logic              lam_en_clr,
  input  logic              hit_clr,
  input  logic              hit_ack_valid,
  input  logic [$clog2(NCH)-1:0] hit_ack_ch,
  input  logic              mod_clr,
  output logic              corr_valid,
  output logic [$clog2(NCH)-1:0] corr_ch,
  output logic [DW-1:0]     corr_data,
  output logic [NCH-1:0]    hit,
  output logic              lam
);
  localparam int CHW = $clog2(NCH);

  logic [DW:0]   ped_mem [NCH];
  logic [DW-1:0] lo_mem  [NCH];
  logic [DW-1:0] hi_mem  [NCH];
  logic [2:0]    ctl_q;
  logic [1:0]    sel_q;
  logic          lam_en_q;

  logic signed [DW+1:0] ped_ext, sum;
  logic [DW-1:0]        corr;
  logic                 pass_lo, pass_hi;
  logic [NCH-1:0]       hit_nxt;

  assign ped_ext = ctl_q[0] ? $signed({ped_mem[conv_ch][DW], ped_mem[conv_ch]}) : '0;
  assign sum     = $signed({2'b00, conv_data}) + ped_ext;
  assign corr    = sum[DW+1] ? '0 : (sum[DW] ? '1 : sum[DW-1:0]);
  assign pass_lo = !ctl_q[1] || (corr >= lo_mem[conv_ch]);
  assign pass_hi = !ctl_q[2] || (corr <= hi_mem[conv_ch]);
  assign lam     = lam_en_q && (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ped_mem[i] <= '0;
        lo_mem[i]  <= '0;
        hi_mem[i]  <= '0;
      end
    end else if (par_we) begin
      case (sel_q)
        2'd0: ped_mem[par_ch] <= par_wdata;
        2'd1: lo_mem[par_ch]  <= par_wdata[DW-1:0];
        2'd2: hi_mem[par_ch]  <= par_wdata[DW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      sel_q    <= '0;
      lam_en_q <= 1'b0;
    end else begin
      if (sel_we) sel_q <= sel_wdata;
      if (mod_clr) begin
        ctl_q    <= '0;
        lam_en_q <= 1'b0;
      end else begin
        if (ctl_we) ctl_q <= ctl_wdata;
        if (lam_en_set) lam_en_q <= 1'b1;
        else if (lam_en_clr) lam_en_q <= 1'b0;
      end
    end
  end

  always_comb begin
    hit_nxt = hit;
    if (hit_clr) hit_nxt = '0;
    if (hit_ack_valid) hit_nxt[hit_ack_ch] = 1'b0;
    if (conv_valid && pass_lo && pass_hi) hit_nxt[conv_ch] = 1'b1;
    if (mod_clr) hit_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit        <= '0;
      corr_valid <= 1'b0;
      corr_ch    <= '0;
      corr_data  <= '0;
    end else begin
      hit        <= hit_nxt;
      corr_valid <= conv_valid && !mod_clr;
      if (conv_valid) begin
        corr_ch   <= conv_ch;
        corr_data <= corr;
      end
    end
  end
endmodule

// File: rtl/hit_window_filter_chk.sv
module hit_window_filter_chk #(
  parameter int NCH = 16,
  parameter int CHW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           conv_valid,
  input logic [CHW-1:0] conv_ch,
  input logic           mod_clr,
  input logic           hit_clr,
  input logic           hit_ack_valid,
  input logic [2:0]     ctl_q,
  input logic           corr_valid,
  input logic [CHW-1:0] corr_ch,
  input logic [NCH-1:0] hit,
  input logic           lam
);
  localparam logic [NCH-1:0] ONE = NCH'(1);

  AST_CORR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid && !mod_clr |=> corr_valid && corr_ch == $past(conv_ch)); // R2
  AST_ALL_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid && !mod_clr && ctl_q == 3'b000 |=> hit[$past(conv_ch)]); // R6
  AST_NO_SPURIOUS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_valid |=> (hit & ~$past(hit)) == '0); // R7
  AST_OWN_BIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |=> (hit & ~$past(hit) & ~(ONE << $past(conv_ch))) == '0); // R7
  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_clr && !hit_ack_valid && !mod_clr |=> ($past(hit) & ~hit) == '0); // R10
  AST_LAM_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lam |-> (|hit)); // R9
  AST_MODCLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mod_clr |=> hit == '0 && !lam); // R11
endmodule

bind hit_window_filter hit_window_filter_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ch(conv_ch),
  .mod_clr(mod_clr), .hit_clr(hit_clr), .hit_ack_valid(hit_ack_valid),
  .ctl_q(ctl_q), .corr_valid(corr_valid), .corr_ch(corr_ch), .hit(hit), .lam(lam)
);

// File: tb/test_hit_window_filter.sv
module test_hit_window_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ctl_we = 0, sel_we = 0, par_we = 0, conv_valid = 0;
  logic [2:0]  ctl_wdata = 0;
  logic [1:0]  sel_wdata = 0;
  logic [3:0]  par_ch = 0, conv_ch = 0, hit_ack_ch = 0, corr_ch;
  logic [12:0] par_wdata = 0;
  logic [11:0] conv_data = 0, corr_data;
  logic        lam_en_set = 0, lam_en_clr = 0, hit_clr = 0, hit_ack_valid = 0, mod_clr = 0;
  logic        corr_valid, lam;
  logic [15:0] hit;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hit_window_filter i_hit_window_filter (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sel_we(sel_we), .sel_wdata(sel_wdata), .par_we(par_we), .par_ch(par_ch),
    .par_wdata(par_wdata), .conv_valid(conv_valid), .conv_ch(conv_ch),
    .conv_data(conv_data), .lam_en_set(lam_en_set), .lam_en_clr(lam_en_clr),
    .hit_clr(hit_clr), .hit_ack_valid(hit_ack_valid), .hit_ack_ch(hit_ack_ch),
    .mod_clr(mod_clr), .corr_valid(corr_valid), .corr_ch(corr_ch),
    .corr_data(corr_data), .hit(hit), .lam(lam)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_ctl(logic [2:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr_par(logic [1:0] sel, int ch, int v);
    @(negedge clk); sel_we = 1; sel_wdata = sel;
    @(negedge clk); sel_we = 0; par_we = 1; par_ch = 4'(ch); par_wdata = 13'(v);
    @(negedge clk); par_we = 0;
  endtask

  task automatic convert(int ch, int v);
    @(negedge clk); conv_valid = 1; conv_ch = 4'(ch); conv_data = 12'(v);
    @(negedge clk); conv_valid = 0;
  endtask

  task automatic pulse_hit_clr();
    @(negedge clk); hit_clr = 1;
    @(negedge clk); hit_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 hit", int'(hit), 0);
    chk("R1 lam", int'(lam), 0);
    chk("R1 corr_valid", int'(corr_valid), 0);
  endtask

  task automatic t_all_off();
    wr_par(2'd1, 3, 500);
    convert(3, 100);
    chk("R2 corr_valid", int'(corr_valid), 1);
    chk("R2 corr_ch", int'(corr_ch), 3);
    chk("R2 raw passthrough", int'(corr_data), 100);
    chk("R6 disabled lower passes", int'(hit[3]), 1);
    chk("R7 own bit only", int'(hit), 16'h0008);
  endtask

  task automatic t_pedestal();
    wr_par(2'd0, 5, 50);
    wr_par(2'd0, 6, -200);
    wr_par(2'd0, 7, 4095);
    set_ctl(3'b001);
    convert(5, 1000);
    chk("R2 offset added", int'(corr_data), 1050);
    convert(6, 100);
    chk("R3 clamp low", int'(corr_data), 0);
    convert(7, 10);
    chk("R3 clamp high", int'(corr_data), 4095);
  endtask

  task automatic t_window();
    wr_par(2'd1, 8, 300);
    wr_par(2'd2, 8, 600);
    set_ctl(3'b110);
    pulse_hit_clr();
    convert(8, 299);
    chk("R4 below lower", int'(hit[8]), 0);
    convert(8, 300);
    chk("R4 at lower", int'(hit[8]), 1);
    pulse_hit_clr();
    convert(8, 600);
    chk("R5 at upper", int'(hit[8]), 1);
    pulse_hit_clr();
    convert(8, 601);
    chk("R5 above upper", int'(hit[8]), 0);
    chk("R5 value still reported", int'(corr_data), 601);
  endtask

  task automatic t_select();
    wr_par(2'd1, 9, 100);
    wr_par(2'd3, 9, 700);
    set_ctl(3'b010);
    pulse_hit_clr();
    convert(9, 150);
    chk("R8 select 3 ignored", int'(hit[9]), 1);
  endtask

  task automatic t_lam();
    set_ctl(3'b000);
    pulse_hit_clr();
    convert(1, 5);
    chk("R9 lam off when disabled", int'(lam), 0);
    @(negedge clk); lam_en_set = 1;
    @(negedge clk); lam_en_set = 0;
    chk("R9 lam on", int'(lam), 1);
    pulse_hit_clr();
    chk("R9 lam drops with no hit", int'(lam), 0);
    convert(2, 5);
    chk("R9 lam returns", int'(lam), 1);
    @(negedge clk); lam_en_clr = 1;
    @(negedge clk); lam_en_clr = 0;
    chk("R9 lam disabled", int'(lam), 0);
  endtask

  task automatic t_clear();
    wr_par(2'd1, 11, 4000);
    set_ctl(3'b000);
    pulse_hit_clr();
    convert(2, 10);
    convert(4, 10);
    set_ctl(3'b010);
    convert(11, 10);
    chk("R7 sticky after fail", int'(hit), 16'h0014);
    @(negedge clk); hit_ack_valid = 1; hit_ack_ch = 4'd2;
    @(negedge clk); hit_ack_valid = 0;
    chk("R10 single ack", int'(hit), 16'h0010);
    set_ctl(3'b000);
    @(negedge clk); hit_clr = 1; conv_valid = 1; conv_ch = 4'd1; conv_data = 12'd7;
    @(negedge clk); hit_clr = 0; conv_valid = 0;
    chk("R10 set wins over clear", int'(hit), 16'h0002);
  endtask

  task automatic t_modclr();
    @(negedge clk); lam_en_set = 1;
    @(negedge clk); lam_en_set = 0;
    set_ctl(3'b111);
    chk("R11 lam before clear", int'(lam), 1);
    @(negedge clk); mod_clr = 1; conv_valid = 1; conv_ch = 4'd12; conv_data = 12'd1;
    @(negedge clk); mod_clr = 0; conv_valid = 0;
    chk("R11 hits cleared", int'(hit), 0);
    chk("R11 lam cleared", int'(lam), 0);
    convert(5, 1000);
    chk("R11 offset disabled", int'(corr_data), 1000);
    chk("R11 lam stays disabled", int'(lam), 0);
    set_ctl(3'b001);
    convert(5, 1000);
    chk("R11 table kept", int'(corr_data), 1050);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_all_off();
    t_pedestal();
    t_window();
    t_select();
    t_lam();
    t_clear();
    t_modclr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule